// File: doc/BRIEF.md
# Hardware RTS/CTS Handshake Controller

This block sits between a receive FIFO of up to sixteen characters, a serial transmitter and the two modem handshake pins of an asynchronous serial port. On the receive side it watches the FIFO fill count. It withdraws the request-to-send line when the count climbs past a programmed threshold, and raises it again once the count drops under that threshold. On the transmit side it passes the clear-to-send input through a synchronizer. It then grants or withholds a transmit permit, and that grant changes only while the transmitter sits between characters.

Both automatic directions are switched on by a pair of enable bits that act only together. With either bit clear, the block falls back to manual behaviour. In that case the request line mirrors a software bit and the permit stays granted whatever the clear-to-send pin does. Every transition of the synchronized clear-to-send level is also reported as a one-cycle modem-status event, in either mode.

Top module: `flowctl_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rts_n_pin` is 1, `tx_permit` is 0 and `cts_event` is 0.
- R2: With automatic mode active, a `rx_level` strictly greater than `rx_thresh` drives `rts_n_pin` to 1 at the next clock edge.
- R3: With automatic mode active, a `rx_level` strictly below `rx_thresh` drives `rts_n_pin` to 0 at the next edge. A level equal to the threshold leaves `rts_n_pin` unchanged.
- R4: Automatic mode is active only when `auto_rts_en` and `auto_cts_en` are both 1. Either bit alone behaves exactly as both clear.
- R5: With automatic mode inactive, `rts_n_pin` equals the inverse of `sw_rts` one edge later, and `tx_permit` is 1 one edge later regardless of `cts_n_pin`.
- R6: `cts_n_pin` is active low and passes through a two-stage synchronizer. With automatic mode active and `tx_idle` high, a pin change reaches `tx_permit` at the third clock edge after it is driven. Pin 0 grants the permit and pin 1 withholds it.
- R7: With automatic mode active and `tx_idle` low (character in progress), `tx_permit` holds its value. A pending CTS change takes effect at the first edge with `tx_idle` high.
- R8: Each transition of `cts_n_pin` produces `cts_event` high for exactly one cycle, from the third clock edge after the transition, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_rts_en | input | 1 | Automatic request-line enable bit |
| auto_cts_en | input | 1 | Automatic clear-line enable bit |
| sw_rts | input | 1 | Software request bit for manual mode (1 = assert) |
| rx_level | input | CNT_W (5) | Receive FIFO fill count, 0..DEPTH |
| rx_thresh | input | CNT_W (5) | Programmed fill threshold |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_idle | input | 1 | Transmitter is at a character boundary |
| rts_n_pin | output | 1 | Request-to-send pin, active low |
| tx_permit | output | 1 | Transmitter may start a character |
| cts_event | output | 1 | One-cycle pulse on a clear-to-send change |

## Verification
The bench keeps the default depth of sixteen, so the count and threshold are five bits wide. At that size it can sweep every level from 0 to 16 against every threshold from 0 to 16. Each pair is applied from both a previously asserted and a previously withdrawn request state, which exercises the equal-level hold from each side. All four enable combinations are crossed with both software bit values. The clear-to-send path is stepped edge by edge to pin down the synchronizer latency, the mid-character hold and the event pulse width.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  typedef enum logic [1:0] {
    LVL_BELOW = 2'd0,
    LVL_EQUAL = 2'd1,
    LVL_ABOVE = 2'd2
  } lvl_cmp_e;

  function automatic lvl_cmp_e compare_level(input logic [7:0] lvl, input logic [7:0] thr);
    if (lvl > thr)      return LVL_ABOVE;
    else if (lvl < thr) return LVL_BELOW;
    else                return LVL_EQUAL;
  endfunction
endpackage

// File: rtl/flowctl_cts_sync.sv
module flowctl_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic level_n,
  output logic changed
);
  logic [STAGES-1:0] chain;
  logic              last_q;
  logic              chg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b1;
      chg_q  <= 1'b0;
    end else begin
      last_q <= chain[STAGES-1];
      chg_q  <= chain[STAGES-1] ^ last_q;
    end
  end

  assign level_n = chain[STAGES-1];
  assign changed = chg_q;
endmodule

// File: rtl/flowctl_rts_ctrl.sv
module flowctl_rts_ctrl
  import flowctl_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_on,
  input  logic             sw_rts,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] rx_thresh,
  output logic             rts_n
);
  logic     rts_n_q;
  logic     rts_n_d;
  lvl_cmp_e cmp;

  always_comb begin
    cmp = compare_level(8'(rx_level), 8'(rx_thresh));
    if (!auto_on) begin
      rts_n_d = ~sw_rts;
    end else begin
      unique case (cmp)
        LVL_ABOVE: rts_n_d = 1'b1;
        LVL_BELOW: rts_n_d = 1'b0;
        default:   rts_n_d = rts_n_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rts_n_q <= 1'b1;
    else     rts_n_q <= rts_n_d;
  end

  assign rts_n = rts_n_q;
endmodule

// File: rtl/flowctl_tx_gate.sv
module flowctl_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic auto_on,
  input  logic cts_n_sync,
  input  logic tx_idle,
  output logic permit
);
  logic permit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      permit_q <= 1'b0;
    end else if (!auto_on) begin
      permit_q <= 1'b1;
    end else if (tx_idle) begin
      permit_q <= ~cts_n_sync;
    end
  end

  assign permit = permit_q;
endmodule

// File: rtl/flowctl_top.sv
module flowctl_top #(
  parameter  int DEPTH       = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             sw_rts,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] rx_thresh,
  input  logic             cts_n_pin,
  input  logic             tx_idle,
  output logic             rts_n_pin,
  output logic             tx_permit,
  output logic             cts_event
);
  logic auto_on;
  logic cts_n_sync;

  assign auto_on = auto_rts_en & auto_cts_en;

  flowctl_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_n   (cts_n_pin),
    .level_n (cts_n_sync),
    .changed (cts_event)
  );

  flowctl_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
    .clk       (clk),
    .rst       (rst),
    .auto_on   (auto_on),
    .sw_rts    (sw_rts),
    .rx_level  (rx_level),
    .rx_thresh (rx_thresh),
    .rts_n     (rts_n_pin)
  );

  flowctl_tx_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .auto_on    (auto_on),
    .cts_n_sync (cts_n_sync),
    .tx_idle    (tx_idle),
    .permit     (tx_permit)
  );
endmodule

// File: rtl/flowctl_chk.sv
module flowctl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             auto_rts_en,
  input logic             auto_cts_en,
  input logic             sw_rts,
  input logic [CNT_W-1:0] rx_level,
  input logic [CNT_W-1:0] rx_thresh,
  input logic             tx_idle,
  input logic             rts_n_pin,
  input logic             tx_permit
);
  logic both_on;
  assign both_on = auto_rts_en && auto_cts_en;

  // R2
  a_r2_rts_withdrawn_above: assert property (@(posedge clk) disable iff (rst)
    (both_on && rx_level > rx_thresh) |=> rts_n_pin);

  // R3
  a_r3_rts_asserted_below: assert property (@(posedge clk) disable iff (rst)
    (both_on && rx_level < rx_thresh) |=> !rts_n_pin);

  // R3
  a_r3_rts_hold_equal: assert property (@(posedge clk) disable iff (rst)
    (both_on && rx_level == rx_thresh) |=> $stable(rts_n_pin));

  // R4, R5
  a_r5_manual_rts: assert property (@(posedge clk) disable iff (rst)
    !both_on |=> (rts_n_pin != $past(sw_rts)));

  // R4, R5
  a_r5_manual_permit: assert property (@(posedge clk) disable iff (rst)
    !both_on |=> tx_permit);

  // R7
  a_r7_hold_mid_char: assert property (@(posedge clk) disable iff (rst)
    (both_on && !tx_idle) |=> $stable(tx_permit));
endmodule

bind flowctl_top flowctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .auto_rts_en (auto_rts_en),
  .auto_cts_en (auto_cts_en),
  .sw_rts      (sw_rts),
  .rx_level    (rx_level),
  .rx_thresh   (rx_thresh),
  .tx_idle     (tx_idle),
  .rts_n_pin   (rts_n_pin),
  .tx_permit   (tx_permit)
);

// File: tb/tb_flowctl_top.sv
`timescale 1ns/1ps
module tb_flowctl_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst;
  logic auto_rts_en, auto_cts_en, sw_rts;
  logic [CNT_W-1:0] rx_level, rx_thresh;
  logic cts_n_pin, tx_idle;
  logic rts_n_pin, tx_permit, cts_event;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flowctl_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .sw_rts(sw_rts), .rx_level(rx_level), .rx_thresh(rx_thresh),
    .cts_n_pin(cts_n_pin), .tx_idle(tx_idle),
    .rts_n_pin(rts_n_pin), .tx_permit(tx_permit), .cts_event(cts_event)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_rts;
    rst = 1'b1; auto_rts_en = 0; auto_cts_en = 0; sw_rts = 0;
    rx_level = '0; rx_thresh = '0; cts_n_pin = 1'b1; tx_idle = 1'b1;
    tick(3);
    // R1: reset state
    chk("R1 rts_n", int'(rts_n_pin), 1);
    chk("R1 permit", int'(tx_permit), 0);
    chk("R1 event", int'(cts_event), 0);
    rst = 1'b0;
    auto_rts_en = 1; auto_cts_en = 1;
    tick(1);
    // R1: first cycle after reset, auto on, level 0 == thresh 0 -> hold 1
    chk("R1 rts_n after release", int'(rts_n_pin), 1);

    // R2/R3 sweep over all level/threshold pairs from both prior states
    for (int th = 0; th <= DEPTH; th++) begin
      for (int lv = 0; lv <= DEPTH; lv++) begin
        rx_thresh = CNT_W'(th);
        if (th > 0) begin
          rx_level = '0; tick(1);
          exp_rts = 0;
          chk("R3 prime low", int'(rts_n_pin), exp_rts);
          rx_level = CNT_W'(lv); tick(1);
          exp_rts = (lv > th) ? 1 : 0;
          chk((lv > th) ? "R2 above from low" : "R3 below/equal from low", int'(rts_n_pin), exp_rts);
        end
        if (th < DEPTH) begin
          rx_level = CNT_W'(DEPTH); tick(1);
          exp_rts = 1;
          chk("R2 prime high", int'(rts_n_pin), exp_rts);
          rx_level = CNT_W'(lv); tick(1);
          exp_rts = (lv < th) ? 0 : 1;
          chk((lv < th) ? "R3 below from high" : "R2/R3 above/equal from high", int'(rts_n_pin), exp_rts);
        end
      end
    end

    // R4/R5: enable combinations crossed with software bit and CTS level
    for (int e = 0; e < 4; e++) begin
      for (int s = 0; s < 2; s++) begin
        for (int c = 0; c < 2; c++) begin
          auto_rts_en = e[0]; auto_cts_en = e[1];
          sw_rts = s[0];
          rx_level = CNT_W'(DEPTH); rx_thresh = '0;
          cts_n_pin = c[0];
          tick(4);
          if (e == 3) begin
            chk("R4 both on rts_n from level", int'(rts_n_pin), 1);
            chk("R4 both on permit from cts", int'(tx_permit), c == 0 ? 1 : 0);
          end else begin
            chk("R4 R5 manual rts_n", int'(rts_n_pin), s == 1 ? 0 : 1);
            chk("R4 R5 manual permit", int'(tx_permit), 1);
          end
        end
      end
    end

    // R6/R8: synchronizer latency with auto on and idle transmitter
    auto_rts_en = 1; auto_cts_en = 1; tx_idle = 1;
    cts_n_pin = 1; tick(5);
    chk("R6 permit withheld", int'(tx_permit), 0);
    cts_n_pin = 0;
    tick(2);
    chk("R6 permit after 2 edges", int'(tx_permit), 0);
    chk("R8 event after 2 edges", int'(cts_event), 0);
    tick(1);
    chk("R6 permit after 3 edges", int'(tx_permit), 1);
    chk("R8 event after 3 edges", int'(cts_event), 1);
    tick(1);
    chk("R8 event width", int'(cts_event), 0);

    // R7: mid-character hold
    tx_idle = 0;
    cts_n_pin = 1;
    tick(3);
    chk("R8 event during character", int'(cts_event), 1);
    tick(3);
    chk("R7 permit held mid-character", int'(tx_permit), 1);
    tx_idle = 1;
    tick(1);
    chk("R7 permit at boundary", int'(tx_permit), 0);

    // R8: event in manual mode too
    auto_rts_en = 0;
    cts_n_pin = 0;
    tick(3);
    chk("R8 event manual mode", int'(cts_event), 1);
    chk("R5 permit manual mode", int'(tx_permit), 1);
    tick(1);
    chk("R8 event manual width", int'(cts_event), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule